// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block applies one microoperation per clock to two operands of `WIDTH` bits. A two-bit group select chooses among three families: arithmetic, bitwise logic, and single-position shifts in either direction. A two-bit operation select and a carry input then pick the operation within that family. The result, a carry-out and an overflow flag are computed combinationally and captured together in an output register on the rising clock edge. A new operation can therefore be issued on every cycle, and its outcome is visible one cycle later.

All arithmetic comes from one ripple adder. A gating stage in front of the adder turns the B operand into B, its complement, all zeros or all ones. Together with the carry input, this one adder performs add, add-with-carry, subtract, increment, decrement and pass-through. The logic family works bit by bit. The two shift units are one parameterised module built twice, once for each direction. In each shift unit, the operation select chooses the bit that enters the vacated end.

Top module: `alsu_top`

## Requirements
- R1: Outputs change only on a rising clock edge and show the result of the inputs present at that edge. While `rst_n` is low at an edge, `f_out`, `c_out` and `v_out` are cleared to 0.
- R2: Group 00 with op 00 gives F = A + B + cin modulo 2^WIDTH. `c_out` is the carry out of the top bit.
- R3: Group 00 with op 01 gives F = A + (not B) + cin. With cin = 1 this is A − B, and `c_out` is 1 exactly when A ≥ B as unsigned values.
- R4: Group 00 with op 10 gives F = A + cin. With cin = 0 this passes A through with `c_out` = 0. With cin = 1 it increments A.
- R5: Group 00 with op 11 gives F = A + all-ones + cin. With cin = 0 this decrements A. With cin = 1 it passes A through with `c_out` = 1.
- R6: In group 00, `v_out` is 1 exactly when the signed two's-complement sum of A, the conditioned B and cin falls outside the signed range of WIDTH bits.
- R7: Group 01 gives a bitwise result chosen by op: 00 A AND B, 01 A OR B, 10 A XOR B, 11 NOT A. `c_out` and `v_out` are 0.
- R8: Group 10 shifts A right by one. The bit entering the MSB is 0 for op 00, A[0] for op 01 (rotate), A[MSB] for op 10 (arithmetic), and cin for op 11. `c_out` is A[0] and `v_out` is 0.
- R9: Group 11 shifts A left by one. The bit entering the LSB is 0 for op 00 and op 10, A[MSB] for op 01 (rotate), and cin for op 11. `c_out` is A[MSB].
- R10: In group 11, `v_out` is 1 only for op 10 (arithmetic), and only when A[MSB] differs from A[MSB−1]. For the other three ops, `v_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B (mask for logic operations) |
| grp_sel | input | 2 | Family: 00 arithmetic, 01 logic, 10 shift right, 11 shift left |
| op_sel | input | 2 | Operation within the family |
| c_in | input | 1 | Carry input; selects the operation in arithmetic and supplies the fill bit in shift-through-carry |
| f_out | output | WIDTH | Registered result |
| c_out | output | 1 | Registered carry-out or shifted-out bit |
| v_out | output | 1 | Registered signed overflow |

## Verification
Carry-out and overflow can both be raised in the same cycle, and so can a shifted-out bit and an overflow. Both cases are provoked on purpose. Adding 0x80 to 0x80 sets the carry and the signed overflow together with a zero result. An arithmetic left shift of 0x80 pushes a 1 out of the top while the sign also flips. The cases on the other side of each boundary are also driven: decrementing 0x80 sets both flags, while decrementing 0x00 gives 0xFF with neither flag. A behavioural model in the bench predicts all three registered outputs every cycle, and all three are judged on every compare.

// File: rtl/alsu_pkg.sv
// Package: shared encodings of the arithmetic logic shift unit.
// Assumes: group and operation selects are two bits wide.
package alsu_pkg;

    // Family picked by the upper select pair.
    typedef enum logic [1:0] {
        GRP_ARITH = 2'b00,
        GRP_LOGIC = 2'b01,
        GRP_SHR   = 2'b10,
        GRP_SHL   = 2'b11
    } alsu_grp_e;

    // Bitwise operation codes of the logic family.
    typedef enum logic [1:0] {
        LOG_AND = 2'b00,
        LOG_OR  = 2'b01,
        LOG_XOR = 2'b10,
        LOG_NOT = 2'b11
    } alsu_logic_e;

    // Fill-bit choice of the shift families.
    typedef enum logic [1:0] {
        SH_LOGICAL = 2'b00,
        SH_ROTATE  = 2'b01,
        SH_ARITH   = 2'b10,
        SH_CARRY   = 2'b11
    } alsu_shift_e;

endpackage

// File: rtl/alsu_arith.sv
// Module: alsu_arith
// Conditions operand B with gates and feeds it, with the carry input, to
// one ripple-carry adder. op[1] gates B to zero and op[0] inverts the gated
// value, giving B, ~B, all-zeros or all-ones.
// Assumes: WIDTH >= 2; purely combinational.
module alsu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_cond;
    logic [WIDTH:0]   carry;

    // Carry input enters the chain at bit 0.
    assign carry[0] = cin;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Gate B, then invert it when op[0] is set.
            assign b_cond[i] = (b[i] & ~op[1]) ^ op[0];
            // One full-adder cell of the ripple chain.
            assign sum[i]     = a[i] ^ b_cond[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b_cond[i]) | (carry[i] & (a[i] ^ b_cond[i]));
        end
    endgenerate

    // Unsigned carry and signed overflow taken from the top of the chain.
    assign cout = carry[WIDTH];
    assign ovf  = carry[WIDTH] ^ carry[MSB];

endmodule

// File: rtl/alsu_logic.sv
// Module: alsu_logic
// Bitwise unit: AND, OR, XOR of the two operands, or the complement of A.
// The same cell is repeated for every bit.
// Assumes: purely combinational; B acts as a mask for selective operations.
module alsu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] res
);
    import alsu_pkg::*;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_cell
            // Per-bit four-way operation chosen by op.
            always_comb begin
                unique case (alsu_logic_e'(op))
                    LOG_AND: res[i] = a[i] & b[i];
                    LOG_OR:  res[i] = a[i] | b[i];
                    LOG_XOR: res[i] = a[i] ^ b[i];
                    default: res[i] = ~a[i];
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/alsu_shift.sv
// Module: alsu_shift
// Shifts one position. SHIFT_LEFT picks the direction at elaboration.
// op chooses the bit that fills the vacated end. The bit pushed out is
// reported as cout. Overflow exists only for the arithmetic left shift.
// Assumes: WIDTH >= 2; purely combinational.
module alsu_shift #(
    parameter int WIDTH      = 8,
    parameter bit SHIFT_LEFT = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [1:0]       op,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ovf
);
    import alsu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic fill;

    generate
        if (SHIFT_LEFT) begin : g_left
            // Fill bit entering the LSB.
            always_comb begin
                unique case (alsu_shift_e'(op))
                    SH_ROTATE: fill = a[MSB];
                    SH_CARRY:  fill = cin;
                    default:   fill = 1'b0;
                endcase
            end
            assign res  = {a[MSB-1:0], fill};
            assign cout = a[MSB];
            assign ovf  = (alsu_shift_e'(op) == SH_ARITH) & (a[MSB] ^ a[MSB-1]);
        end else begin : g_right
            // Fill bit entering the MSB.
            always_comb begin
                unique case (alsu_shift_e'(op))
                    SH_ROTATE: fill = a[0];
                    SH_ARITH:  fill = a[MSB];
                    SH_CARRY:  fill = cin;
                    default:   fill = 1'b0;
                endcase
            end
            assign res  = {fill, a[MSB:1]};
            assign cout = a[0];
            assign ovf  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/alsu_top.sv
// Module: alsu_top
// Arithmetic logic shift unit. Four combinational units work in parallel,
// the group select steers one of them, and the result with its flags is
// registered, so every microoperation takes exactly one clock.
// Assumes: synchronous active-low reset; WIDTH >= 2.
module alsu_top #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       grp_sel,
    input  logic [1:0]       op_sel,
    input  logic             c_in,
    output logic [WIDTH-1:0] f_out,
    output logic             c_out,
    output logic             v_out
);
    import alsu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] ar_res, lg_res, sr_res, sl_res, nxt_res;
    logic             ar_c, ar_v, sr_c, sr_v, sl_c, sl_v, nxt_c, nxt_v;

    alsu_arith #(.WIDTH(WIDTH)) u_arith (
        .a(a_in), .b(b_in), .op(op_sel), .cin(c_in),
        .sum(ar_res), .cout(ar_c), .ovf(ar_v)
    );

    alsu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a_in), .b(b_in), .op(op_sel), .res(lg_res)
    );

    alsu_shift #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b0)) u_shr (
        .a(a_in), .op(op_sel), .cin(c_in),
        .res(sr_res), .cout(sr_c), .ovf(sr_v)
    );

    alsu_shift #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b1)) u_shl (
        .a(a_in), .op(op_sel), .cin(c_in),
        .res(sl_res), .cout(sl_c), .ovf(sl_v)
    );

    // Steer the selected family's result and flags to the register.
    always_comb begin
        unique case (alsu_grp_e'(grp_sel))
            GRP_ARITH: begin nxt_res = ar_res; nxt_c = ar_c; nxt_v = ar_v; end
            GRP_LOGIC: begin nxt_res = lg_res; nxt_c = 1'b0; nxt_v = 1'b0; end
            GRP_SHR:   begin nxt_res = sr_res; nxt_c = sr_c; nxt_v = sr_v; end
            default:   begin nxt_res = sl_res; nxt_c = sl_c; nxt_v = sl_v; end
        endcase
    end

    // Capture the result in one clock; clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_out <= '0;
            c_out <= 1'b0;
            v_out <= 1'b0;
        end else begin
            f_out <= nxt_res;
            c_out <= nxt_c;
            v_out <= nxt_v;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (f_out == '0 && !c_out && !v_out));

    // R4
    xfer_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 2'b00 && op_sel == 2'b10 && !c_in)
        |=> (f_out == $past(a_in) && !c_out && !v_out));

    // R3
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 2'b00 && op_sel == 2'b01 && c_in)
        |=> (c_out == ($past(a_in) >= $past(b_in))));

    // R7
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 2'b01) |=> (!c_out && !v_out));

    // R8
    asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 2'b10 && op_sel == 2'b10)
        |=> (f_out[MSB] == $past(a_in[MSB]) && !v_out));

    // R9
    shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 2'b11) |=> (c_out == $past(a_in[MSB])));

    // R10
    shl_ovf_only_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == 2'b11 && op_sel != 2'b10) |=> !v_out);

endmodule

// File: tb/alsu_top_tb_top.sv
// Bench: a behavioural reference model predicts the registered outputs
// and compares them on every clock.
module alsu_top_tb_top;
    localparam int W    = 8;
    localparam int MOD  = 1 << W;
    localparam int MASK = MOD - 1;
    localparam int SMAX = (MOD / 2) - 1;
    localparam int SMIN = -(MOD / 2);

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic [1:0]   grp_sel, op_sel;
    logic         c_in;
    logic [W-1:0] f_out;
    logic         c_out, v_out;

    int    checks = 0;
    int    errors = 0;
    bit    have_exp = 0;
    int    exp_f;
    bit    exp_c, exp_v;
    string exp_tag;
    bit    finished = 0;

    always #10 clk = ~clk;

    alsu_top #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .grp_sel(grp_sel), .op_sel(op_sel), .c_in(c_in),
        .f_out(f_out), .c_out(c_out), .v_out(v_out)
    );

    function automatic int to_signed(input int v);
        return (v > SMAX) ? v - MOD : v;
    endfunction

    // Reference model: computes the expected outputs for one input set.
    task automatic predict(input bit r, input int g, input int o, input bit c,
                           input int a, input int b);
        int ub, s, sv, msb, lsb;
        msb = (a >> (W - 1)) & 1;
        lsb = a & 1;
        exp_c = 0; exp_v = 0;
        if (!r) begin
            exp_f = 0; exp_tag = "R1";
        end else if (g == 0) begin
            case (o)
                0: begin ub = b;          exp_tag = "R2 R6"; end
                1: begin ub = b ^ MASK;   exp_tag = "R3 R6"; end
                2: begin ub = 0;          exp_tag = "R4 R6"; end
                default: begin ub = MASK; exp_tag = "R5 R6"; end
            endcase
            s  = a + ub + int'(c);
            exp_f = s % MOD;
            exp_c = (s >= MOD);
            sv = to_signed(a) + to_signed(ub) + int'(c);
            exp_v = (sv > SMAX) || (sv < SMIN);
        end else if (g == 1) begin
            exp_tag = "R7";
            case (o)
                0: exp_f = a & b;
                1: exp_f = a | b;
                2: exp_f = a ^ b;
                default: exp_f = a ^ MASK;
            endcase
        end else if (g == 2) begin
            exp_tag = "R8";
            exp_c = lsb[0];
            case (o)
                0: exp_f = a / 2;
                1: exp_f = a / 2 + lsb * (MOD / 2);
                2: exp_f = (to_signed(a) >>> 1) & MASK;
                default: exp_f = a / 2 + int'(c) * (MOD / 2);
            endcase
        end else begin
            exp_tag = "R9 R10";
            exp_c = msb[0];
            case (o)
                0: exp_f = (a * 2) % MOD;
                1: exp_f = (a * 2) % MOD + msb;
                2: begin
                    exp_f = (a * 2) % MOD;
                    sv = to_signed(a) * 2;
                    exp_v = (sv > SMAX) || (sv < SMIN);
                end
                default: exp_f = (a * 2) % MOD + int'(c);
            endcase
        end
    endtask

    // Compare outputs from the last edge, then apply new inputs.
    task automatic step(input bit r, input int g, input int o, input bit c,
                        input int a, input int b);
        @(negedge clk);
        if (have_exp) begin
            checks++;
            if (int'(f_out) != exp_f || c_out != exp_c || v_out != exp_v) begin
                errors++;
                $display("FAIL %s: f=%h c=%b v=%b expected f=%h c=%b v=%b",
                         exp_tag, f_out, c_out, v_out, exp_f[W-1:0], exp_c, exp_v);
            end
        end
        rst_n   = r;
        grp_sel = g[1:0];
        op_sel  = o[1:0];
        c_in    = c;
        a_in    = a[W-1:0];
        b_in    = b[W-1:0];
        predict(r, g, o, c, a, b);
        have_exp = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ops [10];
        int lfsr;
        ops = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h06, 8'h03, 8'hCA, 8'h2E, 8'h8D, 8'h01};
        rst_n = 0; grp_sel = 0; op_sel = 0; c_in = 0; a_in = 0; b_in = 0;
        // R1: reset clears the outputs
        step(0, 0, 0, 0, 8'h55, 8'h0F);
        step(0, 3, 3, 1, 8'hFF, 8'hFF);
        // R2 R3: small add and subtract examples
        step(1, 0, 0, 0, 8'h06, 8'h03);
        step(1, 0, 1, 1, 8'h06, 8'h03);
        // R2 R6: carry and overflow in the same cycle
        step(1, 0, 0, 0, 8'h80, 8'h80);
        // R3: borrow when A < B
        step(1, 0, 1, 1, 8'h03, 8'h06);
        // R4 R5: increment wrap, decrement boundaries, pass-through with carry
        step(1, 0, 2, 1, 8'hFF, 8'h00);
        step(1, 0, 3, 0, 8'h80, 8'h00);
        step(1, 0, 3, 0, 8'h00, 8'h00);
        step(1, 0, 3, 1, 8'h5A, 8'h00);
        // R7: selective set/complement/clear style masks
        step(1, 1, 1, 0, 8'hA3, 8'h0F);
        step(1, 1, 2, 1, 8'hA3, 8'h0F);
        // R8: arithmetic right on a negative value
        step(1, 2, 2, 0, 8'h8D, 8'h00);
        // R9: logical and rotate left examples
        step(1, 3, 0, 0, 8'hCA, 8'h00);
        step(1, 3, 1, 0, 8'h2E, 8'h00);
        // R9 R10: shifted-out bit and overflow together
        step(1, 3, 2, 0, 8'h80, 8'h00);
        step(1, 3, 2, 0, 8'hC0, 8'h00);
        // Sweep every family, op and carry over boundary operands.
        for (int g = 0; g < 4; g++)
            for (int o = 0; o < 4; o++)
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < 10; i++)
                        step(1, g, o, c[0], ops[i], ops[9 - i]);
        // Reset in the middle of traffic (R1).
        step(0, 0, 0, 1, 8'hFF, 8'hFF);
        // Pseudo-random traffic.
        lfsr = 32'h1ACE;
        for (int n = 0; n < 2000; n++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1) ^ n;
            step(1, (lfsr >> 3) & 3, (lfsr >> 5) & 3, lfsr[7],
                 lfsr & MASK, (lfsr >> 8) & MASK);
        end
        step(1, 0, 0, 0, 0, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule